// File: doc/BRIEF.md
# Programmable GPIO Port with Blink and Input Inversion

This block is a general-purpose I/O port with one bit per pin in each of four control registers. A direction bit turns the pin's output driver on or off. When the driver is on, the pin shows the stored output level. Enabled pins with a level of 0 can instead toggle on a shared blink clock. Each pad is synchronized and then passed through a per-pin inverter before it is captured in a data-in register. Software can read that register, so either polarity can be treated as "active".

Software uses a plain synchronous bus with a word address, write data, a write strobe and combinational read data. A write takes effect at the clock edge where the strobe is high. Reads reflect the registers in the same cycle. The blink rate comes from a period register that sets a prescaler, and every blinking pin uses the same phase.

Top module: `gpio_blink_port`

## Requirements
- R1: A direction bit of 1 makes its pin an input, with pad_oe low. A bit of 0 drives pad_oe high, and pad_out shows the level bit unless blink applies.
- R2: Data-in bit n equals pad_in[n] XOR polarity bit n. A pad change made between edges appears in data-in after the third rising edge: two synchronizer stages, then the capture register.
- R3: The word addresses are: direction at 0, output level at 1, blink enable at 2, polarity at 3. Pin n uses bit n of each. A write updates only the addressed register, and reading that address returns the written value.
- R4: A pin that is an output, has blink enabled and has level 0 follows the shared blink phase. With level 1, the pin stays high.
- R5: Reading the output-level register returns the stored value, whatever the pad state, direction or blink setting.
- R6: The period register sits at word address 5, with its value P in bits 15:0. The blink phase toggles once every P+1 clock cycles, and all blinking pins show the same phase.
- R7: After reset, direction reads all ones. Level, blink and polarity read zero, and the period reads 999.
- R8: Word addresses 6 and 7 read as zero. Writes to them change no register.
- R9: Data-in sits at address 4 and is read-only. A write there changes neither data-in nor any other register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 32 | Read data for bus_addr |
| pad_in | input | 32 | Pad levels from the pins |
| pad_out | output | 32 | Output value per pin |
| pad_oe | output | 32 | Output enable per pin |

## Verification
A wrong direction or level register shows at once on pad_oe and pad_out, and also when the register is read back in the same cycle. A fault in the synchronizer or polarity path shows in data-in exactly three edges after a pad change, so the bench samples on both sides of that edge. A bad prescaler count or an extra phase register shows as a toggle interval other than P+1 cycles, or as two blinking pins that disagree. Either is visible within one blink period.

// File: rtl/gpio_pkg.sv
// Shared address map and widths for the GPIO port.
// Assumes a word-addressed bus of GPIO_AW address bits.
package gpio_pkg;
    localparam int GPIO_AW = 3;

    typedef enum logic [GPIO_AW-1:0] {
        A_DIR = 3'd0,
        A_LVL = 3'd1,
        A_BLK = 3'd2,
        A_POL = 3'd3,
        A_DIN = 3'd4,
        A_PER = 3'd5
    } gpio_addr_e;
endpackage

// File: rtl/gpio_regs.sv
// Control register file: direction, level, blink enable, polarity, period.
// Assumes PW <= N. Writes land on the clock edge with wr_en high.
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int N       = 32,
    parameter int PW      = 16,
    parameter int PER_RST = 999
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [GPIO_AW-1:0] wr_addr,
    input  logic [N-1:0]       wr_data,
    output logic [N-1:0]       dir_q,
    output logic [N-1:0]       lvl_q,
    output logic [N-1:0]       blk_q,
    output logic [N-1:0]       pol_q,
    output logic [PW-1:0]      per_q
);
    // Register updates on bus writes; only the addressed register changes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '1;
            lvl_q <= '0;
            blk_q <= '0;
            pol_q <= '0;
            per_q <= PW'(PER_RST);
        end else if (wr_en) begin
            case (wr_addr)
                A_DIR:   dir_q <= wr_data;
                A_LVL:   lvl_q <= wr_data;
                A_BLK:   blk_q <= wr_data;
                A_POL:   pol_q <= wr_data;
                A_PER:   per_q <= wr_data[PW-1:0];
                default: ;
            endcase
        end
    end

    p_dir_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_DIR) |=> (dir_q == $past(wr_data)));

    p_unmapped_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr >= 3'd6) |=>
        ($stable(dir_q) && $stable(lvl_q) && $stable(blk_q) && $stable(pol_q) && $stable(per_q)));
endmodule

// File: rtl/gpio_in_sync.sv
// Pad input path: two-flop synchronizer, polarity XOR, data-in capture.
// Assumes pad_in is asynchronous to clk.
module gpio_in_sync #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pad_in,
    input  logic [N-1:0] pol_q,
    output logic [N-1:0] din_q
);
    logic [N-1:0] s1_q, s2_q;

    // Two synchronizer stages, then the inverted or straight capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q  <= '0;
            s2_q  <= '0;
            din_q <= '0;
        end else begin
            s1_q  <= pad_in;
            s2_q  <= s1_q;
            din_q <= s2_q ^ pol_q;
        end
    end
endmodule

// File: rtl/gpio_blink_gen.sv
// Shared blink phase: prescaler counts 0..per_q, then the phase toggles.
// Assumes per_q may change at any time; a count above it wraps next cycle.
module gpio_blink_gen #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] per_q,
    output logic          phase_q
);
    logic [PW-1:0] cnt_q;

    // Prescaler count and phase toggle on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else if (cnt_q >= per_q) begin
            cnt_q   <= '0;
            phase_q <= ~phase_q;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    p_toggle_on_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q >= per_q) |=> (phase_q != $past(phase_q)));

    p_hold_in_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q < per_q) |=> $stable(phase_q));
endmodule

// File: rtl/gpio_blink_port.sv
// Top of the GPIO port: register file, input path, blink generator,
// per-pin output muxing and the read-data mux.
// Assumes N is at least PW + 1 so the period fits in read data.
module gpio_blink_port
    import gpio_pkg::*;
#(
    parameter int N       = 32,
    parameter int PW      = 16,
    parameter int PER_RST = 999
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [GPIO_AW-1:0] bus_addr,
    input  logic [N-1:0]       bus_wdata,
    input  logic               bus_we,
    output logic [N-1:0]       bus_rdata,
    input  logic [N-1:0]       pad_in,
    output logic [N-1:0]       pad_out,
    output logic [N-1:0]       pad_oe
);
    logic [N-1:0]  dir_q, lvl_q, blk_q, pol_q, din_q;
    logic [PW-1:0] per_q;
    logic          phase_q;

    gpio_regs #(.N(N), .PW(PW), .PER_RST(PER_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_we), .wr_addr(bus_addr),
        .wr_data(bus_wdata), .dir_q(dir_q), .lvl_q(lvl_q), .blk_q(blk_q),
        .pol_q(pol_q), .per_q(per_q)
    );

    gpio_in_sync #(.N(N)) u_in (
        .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .pol_q(pol_q), .din_q(din_q)
    );

    gpio_blink_gen #(.PW(PW)) u_blink (
        .clk(clk), .rst_n(rst_n), .per_q(per_q), .phase_q(phase_q)
    );

    // Per-pin driver: enable from direction, value from level or blink phase.
    for (genvar i = 0; i < N; i++) begin : g_pin
        always_comb begin
            pad_oe[i]  = ~dir_q[i];
            pad_out[i] = lvl_q[i] | (blk_q[i] & phase_q);
        end
    end

    // Read-data mux over the word address map; holes read zero.
    always_comb begin
        case (bus_addr)
            A_DIR:   bus_rdata = dir_q;
            A_LVL:   bus_rdata = lvl_q;
            A_BLK:   bus_rdata = blk_q;
            A_POL:   bus_rdata = pol_q;
            A_DIN:   bus_rdata = din_q;
            A_PER:   bus_rdata = {{(N-PW){1'b0}}, per_q};
            default: bus_rdata = '0;
        endcase
    end

    p_unmapped_rd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr >= 3'd6) |-> (bus_rdata == '0));

    p_no_blink_static_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_q == '0) |-> (pad_out == lvl_q));

    p_din_ro_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_DIN) |=>
        ($stable(dir_q) && $stable(lvl_q) && $stable(blk_q) && $stable(pol_q)));
endmodule

// File: tb/sim_gpio_blink_port.sv
// Scoreboard bench: driver tasks queue expected values, a monitor compares.
module sim_gpio_blink_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;

    int total = 0;
    int bad = 0;
    bit done = 0;

    int          kind_q[$];
    logic [31:0] exp_q[$];
    logic [31:0] mask_q[$];
    logic [31:0] act_q[$];
    string       tag_q[$];
    event        ev_chk;

    always #5 clk = ~clk;

    gpio_blink_port u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    // Monitor: 2 ns after each request, compare every queued item.
    initial begin
        forever begin
            @(ev_chk);
            #2;
            while (kind_q.size() > 0) begin
                automatic int          k = kind_q.pop_front();
                automatic logic [31:0] e = exp_q.pop_front();
                automatic logic [31:0] m = mask_q.pop_front();
                automatic logic [31:0] a = act_q.pop_front();
                automatic string       t = tag_q.pop_front();
                automatic logic [31:0] v;
                case (k)
                    0:       v = bus_rdata;
                    1:       v = pad_out;
                    2:       v = pad_oe;
                    default: v = a;
                endcase
                total++;
                if ((v & m) !== (e & m)) begin
                    bad++;
                    $display("FAIL %s actual=%h expected=%h", t, v & m, e & m);
                end
            end
        end
    end

    task automatic push(input int k, input logic [31:0] e, input logic [31:0] m,
                        input logic [31:0] a, input string t);
        kind_q.push_back(k); exp_q.push_back(e); mask_q.push_back(m);
        act_q.push_back(a); tag_q.push_back(t);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        bus_addr = a;
        push(0, e, '1, '0, t);
        -> ev_chk;
    endtask

    task automatic port_chk(input int k, input logic [31:0] e, input logic [31:0] m,
                            input string t);
        @(negedge clk);
        push(k, e, m, '0, t);
        -> ev_chk;
    endtask

    task automatic val_chk(input logic [31:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        push(3, e, '1, a, t);
        -> ev_chk;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #2000000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        logic prev;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R7 reset values
        rd_chk(3'd0, 32'hFFFF_FFFF, "R7 dir reset");
        rd_chk(3'd1, 32'h0, "R7 level reset");
        rd_chk(3'd2, 32'h0, "R7 blink reset");
        rd_chk(3'd3, 32'h0, "R7 pol reset");
        rd_chk(3'd5, 32'd999, "R7 period reset");
        port_chk(2, 32'h0, '1, "R1 all inputs after reset");

        // R1 / R3 direction and level
        wr(3'd0, 32'hFFFF_0000);
        wr(3'd1, 32'h5A5A_1234);
        rd_chk(3'd0, 32'hFFFF_0000, "R3 dir readback");
        rd_chk(3'd1, 32'h5A5A_1234, "R3 level readback");
        port_chk(2, 32'h0000_FFFF, '1, "R1 output enables");
        port_chk(1, 32'h0000_1234, 32'h0000_FFFF, "R1 output levels");

        // R5 level readback independent of pads
        pad_in = 32'hFFFF_FFFF;
        repeat (4) @(negedge clk);
        rd_chk(3'd1, 32'h5A5A_1234, "R5 level ignores pads");

        // R2 data-in, polarity, latency
        @(negedge clk); pad_in = 32'hA5A5_0F0F;
        @(negedge clk);
        rd_chk(3'd4, 32'hFFFF_FFFF, "R2 old value before third edge");
        rd_chk(3'd4, 32'hA5A5_0F0F, "R2 new value after third edge");
        wr(3'd3, 32'hFFFF_0000);
        repeat (2) @(negedge clk);
        rd_chk(3'd4, 32'h5A5A_0F0F, "R2 inverted upper half");

        // R9 data-in is read-only
        wr(3'd4, 32'h0);
        rd_chk(3'd4, 32'h5A5A_0F0F, "R9 data-in unchanged");
        rd_chk(3'd3, 32'hFFFF_0000, "R9 pol unchanged");

        // R8 unmapped addresses
        wr(3'd6, 32'h1234_5678);
        wr(3'd7, 32'hFFFF_FFFF);
        rd_chk(3'd6, 32'h0, "R8 addr 6 reads zero");
        rd_chk(3'd7, 32'h0, "R8 addr 7 reads zero");
        rd_chk(3'd0, 32'hFFFF_0000, "R8 dir unchanged");
        rd_chk(3'd5, 32'd999, "R8 period unchanged");

        // R4 / R6 blink
        wr(3'd0, 32'hFFFF_FFF8);
        wr(3'd1, 32'h0000_0002);
        wr(3'd5, 32'd3);
        wr(3'd2, 32'h0000_0007);
        rd_chk(3'd1, 32'h0000_0002, "R5 level unaffected by blink");
        @(negedge clk); prev = pad_out[0];
        n = 0;
        while (pad_out[0] == prev && n < 50) begin @(negedge clk); n++; end
        prev = pad_out[0];
        n = 0;
        do begin @(negedge clk); n++; end while (pad_out[0] == prev && n < 50);
        val_chk(32'(n), 32'd4, "R6 toggle interval P+1");
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            total++;
            if (pad_out[2] !== pad_out[0] || pad_out[1] !== 1'b1) begin
                bad++;
                $display("FAIL R4 shared phase / level-1 hold actual=%b expected=%b1%b",
                         pad_out[2:0], pad_out[0], pad_out[0]);
            end
        end
        wr(3'd2, 32'h0);
        port_chk(1, 32'h0000_0002, 32'h0000_0007, "R4 static after blink off");

        repeat (3) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule